// File: doc/BRIEF.md
# Memory-Side Pointer Operation Unit

This block owns a word-addressed memory array. It carries out single-request operations that follow a pointer stored inside that memory, so a requester reaches the pointed-to data without a second round trip. A request carries an opcode, an address, an index, a first operand and a second operand. It is accepted over a valid/ready handshake. The unit then performs its internal pointer read, optional index addition, data access and optional pointer write-back. It finishes with a one-cycle response that holds read data and an error flag.

Requests are processed strictly one at a time. No other request touches the array between the pointer read and the last write of the current one, so every opcode is atomic without locks. Addresses and pointers are word indices as wide as the data word. Any address or pointer at or beyond the array depth is refused with an error, so the requester can fall back to direct addressing.

Top module: `ptr_op_unit`

## Requirements
- R1: Opcode 0 (plain indirect load) reads the pointer word at the request address and returns the word at that pointer.
- R2: Opcode 3 (plain indirect store) writes the first operand to the word the pointer at the request address names, and returns data 0.
- R3: Opcodes 1, 4 and 9 add the index to the request address before the pointer is fetched, so the index chooses which pointer to follow. Opcode 1 is a load, 4 a store and 9 an add.
- R4: Opcodes 2, 5 and 10 add the index to the fetched pointer, so the index chooses a field of the pointed-to record. Opcode 2 is a load, 5 a store and 10 an add.
- R5: Opcode 6 (fetch-and-add-indirect) returns the word named by the old pointer and adds the first operand to the stored pointer, modulo 2^DATA_W.
- R6: Opcode 7 (store-and-add-indirect) writes the second operand where the stored pointer points, adds the first operand to the pointer word, and returns data 0.
- R7: Opcodes 8, 9 and 10 add the first operand to their target word, which the pointer names either without the index or with it.
- R8: Opcode 11 (compare-and-swap) returns the old word at the request address. It writes the second operand there only if the old word equals the first operand; otherwise the word is left unchanged.
- R9: If the pointer-word address or the target pointer is at or beyond MEM_DEPTH, the response has error 1 and data 0, and no word of the array changes. This includes the pointer update of opcode 6.
- R10: Opcode 12 (fence) responds with data 0 and error 0. Opcodes 13 to 15 are reserved and respond with error 1 without touching the array.
- R11: reqReady is low from the accepting edge until the response. rspValid is high for exactly one cycle. It rises one clock edge after the accepting edge for compare-and-swap, fence, reserved opcodes and a pointer-word address error, and two edges after it otherwise.
- R12: After reset reqReady is 1, rspValid is 0 and every array word is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Request present |
| reqReady | output | 1 | Unit idle and able to accept |
| reqOp | input | 4 | Opcode |
| reqAddr | input | DATA_W | Request word address |
| reqIdx | input | DATA_W | Index |
| reqVal | input | DATA_W | First operand (store value, addend, compare value) |
| reqVal2 | input | DATA_W | Second operand (swap value, stored value of opcode 7) |
| rspValid | output | 1 | Response strobe, one cycle |
| rspData | output | DATA_W | Returned word, 0 when nothing is returned |
| rspErr | output | 1 | Operation refused |

## Verification
The bench builds the unit with DATA_W = 16 and MEM_DEPTH = 64. A 16-bit pointer can name addresses far past the 64-word array, so both error paths (bad pointer-word address, bad target pointer) are reachable with ordinary operands. A single 16-bit addend of 0xFFC1 carries pointer 63 across the 2^16 boundary to 0, which exercises the wrap of fetch-and-add-indirect. Compare-and-swap doubles as the bench's direct read and write path.

// File: rtl/ptr_op_pkg.sv
package ptr_op_pkg;

  typedef enum logic [3:0] {
    OP_LDI    = 4'd0,
    OP_LDI_A  = 4'd1,
    OP_LDI_P  = 4'd2,
    OP_STI    = 4'd3,
    OP_STI_A  = 4'd4,
    OP_STI_P  = 4'd5,
    OP_FAAI   = 4'd6,
    OP_SAAI   = 4'd7,
    OP_ADDI   = 4'd8,
    OP_ADDI_A = 4'd9,
    OP_ADDI_P = 4'd10,
    OP_CAS    = 4'd11,
    OP_FENCE  = 4'd12
  } opcode_t;

  // strobes from control to datapath
  typedef struct packed {
    logic capture;
    logic fetch;
    logic access;
  } strobe_t;

  function automatic logic idxOnAddr(input logic [3:0] op);
    return (op == OP_LDI_A) || (op == OP_STI_A) || (op == OP_ADDI_A);
  endfunction

  function automatic logic idxOnPtr(input logic [3:0] op);
    return (op == OP_LDI_P) || (op == OP_STI_P) || (op == OP_ADDI_P);
  endfunction

  function automatic logic isKnown(input logic [3:0] op);
    return op <= OP_FENCE;
  endfunction

endpackage

// File: rtl/ptr_op_ctrl.sv
module ptr_op_ctrl
  import ptr_op_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    reqValid,
  input  logic    fetchEnds,
  output logic    reqReady,
  output logic    rspValid,
  output strobe_t stb
);

  typedef enum logic [1:0] {S_IDLE, S_FETCH, S_ACCESS, S_DONE} state_t;
  state_t state, stateNext;

  always_comb begin
    stateNext   = state;
    stb         = '0;
    unique case (state)
      S_IDLE: if (reqValid) begin
        stb.capture = 1'b1;
        stateNext   = S_FETCH;
      end
      S_FETCH: begin
        stb.fetch = 1'b1;
        stateNext = fetchEnds ? S_DONE : S_ACCESS;
      end
      S_ACCESS: begin
        stb.access = 1'b1;
        stateNext  = S_DONE;
      end
      S_DONE: stateNext = S_IDLE;
      default: stateNext = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= S_IDLE;
    else       state <= stateNext;
  end

  assign reqReady = (state == S_IDLE);
  assign rspValid = (state == S_DONE);

endmodule

// File: rtl/ptr_op_dp.sv
module ptr_op_dp
  import ptr_op_pkg::*;
#(
  parameter int DATA_W    = 16,
  parameter int MEM_DEPTH = 64
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           stb,
  input  logic [3:0]        reqOp,
  input  logic [DATA_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqIdx,
  input  logic [DATA_W-1:0] reqVal,
  input  logic [DATA_W-1:0] reqVal2,
  output logic              fetchEnds,
  output logic [DATA_W-1:0] resData,
  output logic              resErr
);

  localparam int AW = (MEM_DEPTH > 1) ? $clog2(MEM_DEPTH) : 1;
  localparam logic [DATA_W-1:0] LIMIT = DATA_W'(MEM_DEPTH);

  logic [DATA_W-1:0] mem [MEM_DEPTH];
  logic [3:0]        opR;
  logic [DATA_W-1:0] addrR, idxR, valR, val2R, ptrAddrR, ptrR;

  logic [DATA_W-1:0] ptrAddr, ptrWord, tgt, tgtWord;
  logic              ptrOk, tgtOk;

  always_comb begin
    ptrAddr   = addrR + (idxOnAddr(opR) ? idxR : '0);
    ptrOk     = ptrAddr < LIMIT;
    ptrWord   = ptrOk ? mem[ptrAddr[AW-1:0]] : '0;
    tgt       = ptrR + (idxOnPtr(opR) ? idxR : '0);
    tgtOk     = tgt < LIMIT;
    tgtWord   = tgtOk ? mem[tgt[AW-1:0]] : '0;
    fetchEnds = !isKnown(opR) || (opR == OP_FENCE) || (opR == OP_CAS) || !ptrOk;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < MEM_DEPTH; i++) mem[i] <= '0;
      {opR, addrR, idxR, valR, val2R, ptrAddrR, ptrR} <= '0;
      resData <= '0;
      resErr  <= 1'b0;
    end else begin
      if (stb.capture) begin
        opR     <= reqOp;
        addrR   <= reqAddr;
        idxR    <= reqIdx;
        valR    <= reqVal;
        val2R   <= reqVal2;
        resData <= '0;
        resErr  <= 1'b0;
      end
      if (stb.fetch) begin
        ptrAddrR <= ptrAddr;
        ptrR     <= ptrWord;
        if (!isKnown(opR)) resErr <= 1'b1;
        else if (opR == OP_FENCE) resErr <= 1'b0;
        else if (!ptrOk) resErr <= 1'b1;
        else if (opR == OP_CAS) begin
          resData <= ptrWord;
          if (ptrWord == valR) mem[ptrAddr[AW-1:0]] <= val2R;
        end
      end
      if (stb.access) begin
        if (!tgtOk) resErr <= 1'b1;
        else begin
          case (opcode_t'(opR))
            OP_LDI, OP_LDI_A, OP_LDI_P: resData <= tgtWord;
            OP_STI, OP_STI_A, OP_STI_P: mem[tgt[AW-1:0]] <= valR;
            OP_ADDI, OP_ADDI_A, OP_ADDI_P: mem[tgt[AW-1:0]] <= tgtWord + valR;
            OP_FAAI: begin
              resData <= tgtWord;
              mem[ptrAddrR[AW-1:0]] <= ptrR + valR;
            end
            OP_SAAI: begin
              mem[tgt[AW-1:0]]      <= val2R;
              mem[ptrAddrR[AW-1:0]] <= ptrR + valR;
            end
            default: resErr <= 1'b1;
          endcase
        end
      end
    end
  end

endmodule

// File: rtl/ptr_op_unit.sv
module ptr_op_unit
  import ptr_op_pkg::*;
#(
  parameter int DATA_W    = 16,
  parameter int MEM_DEPTH = 64
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  output logic              reqReady,
  input  logic [3:0]        reqOp,
  input  logic [DATA_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqIdx,
  input  logic [DATA_W-1:0] reqVal,
  input  logic [DATA_W-1:0] reqVal2,
  output logic              rspValid,
  output logic [DATA_W-1:0] rspData,
  output logic              rspErr
);

  strobe_t           stb;
  logic              fetchEnds;
  logic [DATA_W-1:0] resData;
  logic              resErr;

  ptr_op_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .fetchEnds(fetchEnds),
    .reqReady(reqReady), .rspValid(rspValid), .stb(stb)
  );

  ptr_op_dp #(.DATA_W(DATA_W), .MEM_DEPTH(MEM_DEPTH)) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .reqOp(reqOp), .reqAddr(reqAddr),
    .reqIdx(reqIdx), .reqVal(reqVal), .reqVal2(reqVal2),
    .fetchEnds(fetchEnds), .resData(resData), .resErr(resErr)
  );

  assign rspData = rspValid ? resData : '0;
  assign rspErr  = rspValid & resErr;

endmodule

// File: rtl/ptr_op_checker.sv
module ptr_op_checker #(
  parameter int DATA_W = 16
) (
  input logic              clk,
  input logic              rstN,
  input logic              reqValid,
  input logic              reqReady,
  input logic [3:0]        reqOp,
  input logic              rspValid,
  input logic [DATA_W-1:0] rspData,
  input logic              rspErr
);

  logic       pending;
  logic [2:0] edgeCnt;
  logic [3:0] lastOp;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pending <= 1'b0;
      edgeCnt <= '0;
      lastOp  <= '0;
    end else if (reqValid && reqReady) begin
      pending <= 1'b1;
      edgeCnt <= '0;
      lastOp  <= reqOp;
    end else if (rspValid) begin
      pending <= 1'b0;
    end else if (pending && edgeCnt != 3'd7) begin
      edgeCnt <= edgeCnt + 3'd1;
    end
  end

  p_busy_after_accept_r11: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqReady) |=> !reqReady);

  p_single_pulse_r11: assert property (@(posedge clk) disable iff (!rstN)
    rspValid |=> !rspValid);

  p_no_ready_on_rsp_r11: assert property (@(posedge clk) disable iff (!rstN)
    !(rspValid && reqReady));

  p_rsp_latency_r11: assert property (@(posedge clk) disable iff (!rstN)
    rspValid |-> (pending && (edgeCnt == 3'd1 || edgeCnt == 3'd2)));

  p_err_no_data_r9: assert property (@(posedge clk) disable iff (!rstN)
    rspErr |-> (rspValid && rspData == '0));

  p_fence_clean_r10: assert property (@(posedge clk) disable iff (!rstN)
    (rspValid && lastOp == 4'd12) |-> (rspData == '0 && !rspErr));

  p_reserved_err_r10: assert property (@(posedge clk) disable iff (!rstN)
    (rspValid && lastOp >= 4'd13) |-> rspErr);

endmodule

bind ptr_op_unit ptr_op_checker #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
  .reqOp(reqOp), .rspValid(rspValid), .rspData(rspData), .rspErr(rspErr)
);

// File: tb/sim_ptr_op_unit.sv
module sim_ptr_op_unit;

  localparam int W = 16;
  localparam int DEPTH = 64;

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         reqValid = 1'b0;
  logic         reqReady;
  logic [3:0]   reqOp = '0;
  logic [W-1:0] reqAddr = '0, reqIdx = '0, reqVal = '0, reqVal2 = '0;
  logic         rspValid;
  logic [W-1:0] rspData;
  logic         rspErr;

  int nChecks = 0;
  int nFail = 0;
  logic [W-1:0] model [DEPTH];

  always #10 clk = ~clk;

  ptr_op_unit #(.DATA_W(W), .MEM_DEPTH(DEPTH)) u0 (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
    .reqOp(reqOp), .reqAddr(reqAddr), .reqIdx(reqIdx), .reqVal(reqVal),
    .reqVal2(reqVal2), .rspValid(rspValid), .rspData(rspData), .rspErr(rspErr)
  );

  task automatic check(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic doReq(input logic [3:0] op, input logic [W-1:0] a, i, v, v2,
                       output logic [W-1:0] d, output logic e, output int lat);
    @(negedge clk);
    reqOp = op; reqAddr = a; reqIdx = i; reqVal = v; reqVal2 = v2; reqValid = 1'b1;
    @(posedge clk);
    d = '0; e = 1'b0;
    @(negedge clk);
    reqValid = 1'b0;
    lat = 1;
    check("R11 busy after accept", W'(reqReady), '0);
    while (lat < 10) begin
      if (rspValid) begin
        d = rspData; e = rspErr;
        break;
      end
      @(negedge clk);
      lat++;
    end
  endtask

  task automatic poke(input int a, input logic [W-1:0] v);
    logic [W-1:0] d; logic e; int lat;
    doReq(4'd11, W'(a), '0, model[a], v, d, e, lat);
    check("R8 swap returns old word", d, model[a]);
    model[a] = v;
  endtask

  task automatic peekCheck(input string tag, input int a);
    logic [W-1:0] d; logic e; int lat;
    doReq(4'd11, W'(a), '0, model[a] + 1'b1, 16'h0, d, e, lat);
    check(tag, d, model[a]);
  endtask

  task automatic t_reset;
    check("R12 ready after reset", W'(reqReady), 16'd1);
    check("R12 no response after reset", W'(rspValid), '0);
    peekCheck("R12 array cleared", 5);
    peekCheck("R12 array cleared", 63);
  endtask

  task automatic t_load;
    logic [W-1:0] d; logic e; int lat;
    poke(10, 16'd20); poke(20, 16'hABCD); poke(21, 16'h1234);
    doReq(4'd0, 16'd10, 16'd0, '0, '0, d, e, lat);
    check("R1 plain indirect load", d, 16'hABCD);
    check("R11 long latency", W'(lat), 16'd3);
    doReq(4'd1, 16'd8, 16'd2, '0, '0, d, e, lat);
    check("R3 index before fetch load", d, 16'hABCD);
    doReq(4'd2, 16'd10, 16'd1, '0, '0, d, e, lat);
    check("R4 index after fetch load", d, 16'h1234);
  endtask

  task automatic t_store;
    logic [W-1:0] d; logic e; int lat;
    doReq(4'd3, 16'd10, 16'd0, 16'h5555, '0, d, e, lat);
    check("R2 store returns no data", d, '0);
    model[20] = 16'h5555;
    peekCheck("R2 plain indirect store", 20);
    poke(11, 16'd22);
    doReq(4'd4, 16'd9, 16'd2, 16'h6666, '0, d, e, lat);
    model[22] = 16'h6666;
    peekCheck("R3 index before fetch store", 22);
    doReq(4'd5, 16'd10, 16'd3, 16'h7777, '0, d, e, lat);
    model[23] = 16'h7777;
    peekCheck("R4 index after fetch store", 23);
  endtask

  task automatic t_faai;
    logic [W-1:0] d; logic e; int lat;
    poke(30, 16'd40); poke(40, 16'd7); poke(41, 16'd9);
    doReq(4'd6, 16'd30, '0, 16'd1, '0, d, e, lat);
    check("R5 fetch-add first", d, 16'd7);
    doReq(4'd6, 16'd30, '0, 16'd1, '0, d, e, lat);
    check("R5 fetch-add second", d, 16'd9);
    model[30] = 16'd42;
    peekCheck("R5 pointer advanced", 30);
    poke(33, 16'd63); poke(63, 16'h0BAD);
    doReq(4'd6, 16'd33, '0, 16'hFFC1, '0, d, e, lat);
    check("R5 wrap returns old target", d, 16'h0BAD);
    model[33] = 16'd0;
    peekCheck("R5 pointer wraps modulo width", 33);
  endtask

  task automatic t_saai;
    logic [W-1:0] d; logic e; int lat;
    poke(32, 16'd50);
    doReq(4'd7, 16'd32, '0, 16'd2, 16'h0077, d, e, lat);
    check("R6 store-add no data", d, '0);
    model[50] = 16'h0077; model[32] = 16'd52;
    peekCheck("R6 second operand stored", 50);
    peekCheck("R6 pointer advanced", 32);
  endtask

  task automatic t_add;
    logic [W-1:0] d; logic e; int lat;
    poke(12, 16'd25); poke(25, 16'd100); poke(26, 16'd1);
    doReq(4'd8, 16'd12, '0, 16'd5, '0, d, e, lat);
    model[25] = 16'd105;
    peekCheck("R7 plain indirect add", 25);
    doReq(4'd9, 16'd11, 16'd1, 16'd1, '0, d, e, lat);
    model[25] = 16'd106;
    peekCheck("R7 R3 add index before fetch", 25);
    doReq(4'd10, 16'd12, 16'd1, 16'd3, '0, d, e, lat);
    model[26] = 16'd4;
    peekCheck("R7 R4 add index after fetch", 26);
  endtask

  task automatic t_cas;
    logic [W-1:0] d; logic e; int lat;
    poke(5, 16'd9);
    doReq(4'd11, 16'd5, '0, 16'd3, 16'd4, d, e, lat);
    check("R8 failed swap returns old", d, 16'd9);
    check("R11 short latency swap", W'(lat), 16'd2);
    peekCheck("R8 failed swap leaves word", 5);
    doReq(4'd11, 16'd5, '0, 16'd9, 16'd4, d, e, lat);
    check("R8 good swap returns old", d, 16'd9);
    model[5] = 16'd4;
    peekCheck("R8 good swap writes", 5);
  endtask

  task automatic t_err;
    logic [W-1:0] d; logic e; int lat;
    poke(14, 16'd200);
    doReq(4'd0, 16'd14, '0, '0, '0, d, e, lat);
    check("R9 bad pointer flags error", W'(e), 16'd1);
    check("R9 bad pointer data zero", d, '0);
    doReq(4'd6, 16'd14, '0, 16'd1, '0, d, e, lat);
    check("R9 fetch-add refused", W'(e), 16'd1);
    peekCheck("R9 pointer not advanced", 14);
    doReq(4'd0, 16'd100, '0, '0, '0, d, e, lat);
    check("R9 bad address flags error", W'(e), 16'd1);
    check("R11 short latency address error", W'(lat), 16'd2);
    doReq(4'd3, 16'd14, '0, 16'h1111, '0, d, e, lat);
    check("R9 store refused", W'(e), 16'd1);
  endtask

  task automatic t_fence;
    logic [W-1:0] d; logic e; int lat;
    doReq(4'd12, 16'd0, '0, '0, '0, d, e, lat);
    check("R10 fence no error", W'(e), '0);
    check("R10 fence latency", W'(lat), 16'd2);
    doReq(4'd14, 16'd5, '0, '0, '0, d, e, lat);
    check("R10 reserved opcode error", W'(e), 16'd1);
    peekCheck("R10 reserved leaves array", 5);
  endtask

  initial begin
    for (int k = 0; k < DEPTH; k++) model[k] = '0;
    repeat (3) @(posedge clk);
    @(negedge clk) rstN = 1'b1;
    @(negedge clk);
    t_reset; t_load; t_store; t_faai; t_saai; t_add; t_cas; t_err; t_fence;
    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    nChecks++; nFail++;
    $display("FAIL R11 watchdog actual=hung expected=done");
    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  end

endmodule